// File: doc/BRIEF.md
# Reference Selector and PLL Mode Sequencer

This block decides which of several qualified timing references feeds a digital PLL, and steps the PLL through its operating modes. Each reference arrives with a qualification flag from an upstream monitor and a priority value. In automatic operation the block picks the best qualified reference. In manual operation it uses the index given on a control input. A revertive setting chooses whether a better reference that comes back takes over again, or whether the reference in use is kept for as long as it stays qualified.

The mode sequencer starts in free-run. It moves to acquiring once a usable reference exists, and to locked once the phase detector has reported lock for a programmable number of consecutive cycles. It drops to holdover on the edge after the last usable reference disappears, and it leaves holdover as soon as a reference requalifies. Every change of the selected index outside free-run raises a one-cycle strobe, which the phase build-out logic uses to absorb the phase step. A bandwidth select output tells the loop filter whether the acquisition or the locked coefficient set applies. The loop filter, the phase detector and the holdover averaging are separate blocks.

Top module: `refsel_mode_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `mode` is free-run (code 0), `selIdx` is 0, and `switchStrobe` and `bwLocked` are 0.
- R2: In automatic mode the candidate is the qualified reference with the numerically lowest priority value in `refPrio` (reference i in bits i*PRIO_W upward). A tie goes to the lowest index.
- R3: In manual mode the candidate is `manualIdx` alone. If that reference is unqualified there is no candidate, even when other references are qualified.
- R4: In automatic revertive mode (`revertEn`=1), a reference that becomes the best candidate replaces the current one on the next edge, even while the current one is still qualified.
- R5: In automatic non-revertive mode (`revertEn`=0), while the mode is acquiring or locked and the current reference stays qualified, it is kept. When it is lost, the best qualified reference is taken.
- R6: From free-run, the mode becomes acquiring (code 1) and `selIdx` takes the candidate on the edge after a candidate exists. Otherwise the mode stays free-run.
- R7: In acquiring, the mode becomes locked (code 2) on the edge where `pdLocked` has been sampled high for `lockDwell` consecutive acquiring cycles without a reference change. A low `pdLocked` restarts the count, and a `lockDwell` of 0 behaves like 1.
- R8: From acquiring or locked, loss of every candidate gives holdover (code 3) on the next edge. From holdover, the next edge after a candidate appears gives acquiring with that candidate selected.
- R9: `switchStrobe` is high for exactly the cycle in which `selIdx` shows a new value, and only when the mode before the change was not free-run.
- R10: `bwLocked` is high exactly when the mode is locked.
- R11: From locked, a change of candidate or a low `pdLocked` returns the mode to acquiring on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refValid | input | NUM_REFS | Per-reference qualified flag |
| refPrio | input | NUM_REFS*PRIO_W | Packed per-reference priority; a lower value is preferred |
| manualMode | input | 1 | 1 = manual selection, 0 = automatic |
| manualIdx | input | IDX_W | Reference index used in manual mode |
| revertEn | input | 1 | 1 = revertive automatic selection |
| pdLocked | input | 1 | Lock indication from the phase detector |
| lockDwell | input | LOCK_W | Consecutive lock cycles needed to enter locked |
| selIdx | output | IDX_W | Selected reference index |
| mode | output | 2 | 0 free-run, 1 acquiring, 2 locked, 3 holdover |
| switchStrobe | output | 1 | One-cycle phase build-out request on a reference change |
| bwLocked | output | 1 | 1 = locked loop bandwidth, 0 = acquisition bandwidth |

## Verification
The bench builds the block with four references and 3-bit priorities, so priority ties and all-equal priority sets can be produced. A 4-bit dwell field covers the zero dwell, dwells of one and three cycles, and a count that is interrupted part way. Directed sequences cover revertive take-back, non-revertive hold, holdover entry and exit, and manual selection of an unqualified input. A long stretch of randomly varying qualification, priority, lock and mode inputs then runs, with every output compared each cycle against a behavioural model.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_LOCK = 2'd2,
    MODE_HOLD = 2'd3
  } pll_mode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic keepCur;  // current reference is in service (acquiring/locked)
    logic loadSel;  // capture candidate into the selection register
    logic pulseSw;  // raise the phase build-out strobe
    logic clrCnt;   // clear lock dwell counter
    logic incCnt;   // advance lock dwell counter
  } sel_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic candOk;   // a usable candidate exists
    logic candDiff; // candidate differs from the current selection
    logic dwellMet; // this lock cycle completes the dwell
  } sel_sts_t;

endpackage

// File: rtl/refsel_dp.sv
module refsel_dp
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int PRIO_W   = 4,
  parameter int LOCK_W   = 8,
  parameter int IDX_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REFS-1:0]        refValid,
  input  logic [NUM_REFS*PRIO_W-1:0] refPrio,
  input  logic                       manualMode,
  input  logic [IDX_W-1:0]           manualIdx,
  input  logic                       revertEn,
  input  logic [LOCK_W-1:0]          lockDwell,
  input  sel_ctl_t                   ctl,
  output sel_sts_t                   sts,
  output logic [IDX_W-1:0]           selIdx,
  output logic                       switchStrobe
);

  logic [PRIO_W-1:0] prioArr [NUM_REFS];
  logic [IDX_W-1:0]  selReg;
  logic              swReg;
  logic [LOCK_W-1:0] cnt;

  logic [IDX_W-1:0]  bestIdx;
  logic              bestOk;
  logic [PRIO_W-1:0] bestPri;
  logic [IDX_W-1:0]  cand;
  logic              candOk;
  logic              manOk;
  logic              curOk;

  genvar g;
  generate
    for (g = 0; g < NUM_REFS; g++) begin : g_prio
      assign prioArr[g] = refPrio[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  // priority search: strict compare keeps the lowest index on a tie
  always_comb begin
    bestOk  = 1'b0;
    bestIdx = '0;
    bestPri = '1;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (refValid[i] && (!bestOk || (prioArr[i] < bestPri))) begin
        bestOk  = 1'b1;
        bestIdx = IDX_W'(i);
        bestPri = prioArr[i];
      end
    end
  end

  always_comb begin
    manOk = (int'(manualIdx) < NUM_REFS) && refValid[manualIdx];
    curOk = refValid[selReg];
    if (manualMode) begin
      cand   = manualIdx;
      candOk = manOk;
    end else if (!revertEn && ctl.keepCur && curOk) begin
      cand   = selReg;
      candOk = 1'b1;
    end else begin
      cand   = bestIdx;
      candOk = bestOk;
    end
  end

  assign sts.candOk   = candOk;
  assign sts.candDiff = (cand != selReg);
  assign sts.dwellMet = (({1'b0, cnt} + {{LOCK_W{1'b0}}, 1'b1}) >= {1'b0, lockDwell});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      swReg  <= 1'b0;
      cnt    <= '0;
    end else begin
      if (ctl.loadSel) selReg <= cand;
      swReg <= ctl.pulseSw;
      if (ctl.clrCnt)                     cnt <= '0;
      else if (ctl.incCnt && (cnt != '1)) cnt <= cnt + 1'b1;
    end
  end

  assign selIdx       = selReg;
  assign switchStrobe = swReg;

  AST_STROBE_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    swReg |-> (selReg != $past(selReg)));                        // R9

  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadSel && manualMode) |=> (selReg == $past(manualIdx))); // R3

endmodule

// File: rtl/refsel_ctl.sv
module refsel_ctl
  import refsel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdLocked,
  input  sel_sts_t  sts,
  output sel_ctl_t  ctl,
  output pll_mode_t mode
);

  pll_mode_t modeQ, modeD;

  always_comb begin
    ctl         = '0;
    modeD       = modeQ;
    ctl.keepCur = (modeQ == MODE_ACQ) || (modeQ == MODE_LOCK);
    unique case (modeQ)
      MODE_FREE: begin
        if (sts.candOk) begin
          ctl.loadSel = 1'b1;
          ctl.clrCnt  = 1'b1;
          modeD       = MODE_ACQ;
        end
      end
      MODE_ACQ: begin
        if (!sts.candOk) begin
          ctl.clrCnt = 1'b1;
          modeD      = MODE_HOLD;
        end else if (sts.candDiff) begin
          ctl.loadSel = 1'b1;
          ctl.pulseSw = 1'b1;
          ctl.clrCnt  = 1'b1;
        end else if (pdLocked) begin
          if (sts.dwellMet) begin
            ctl.clrCnt = 1'b1;
            modeD      = MODE_LOCK;
          end else begin
            ctl.incCnt = 1'b1;
          end
        end else begin
          ctl.clrCnt = 1'b1;
        end
      end
      MODE_LOCK: begin
        if (!sts.candOk) begin
          ctl.clrCnt = 1'b1;
          modeD      = MODE_HOLD;
        end else if (sts.candDiff) begin
          ctl.loadSel = 1'b1;
          ctl.pulseSw = 1'b1;
          ctl.clrCnt  = 1'b1;
          modeD       = MODE_ACQ;
        end else if (!pdLocked) begin
          ctl.clrCnt = 1'b1;
          modeD      = MODE_ACQ;
        end
      end
      MODE_HOLD: begin
        if (sts.candOk) begin
          ctl.loadSel = 1'b1;
          ctl.pulseSw = sts.candDiff;
          ctl.clrCnt  = 1'b1;
          modeD       = MODE_ACQ;
        end
      end
      default: modeD = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_FREE;
    else       modeQ <= modeD;
  end

  assign mode = modeQ;

  AST_FREE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FREE) |=> ((modeQ == MODE_FREE) || (modeQ == MODE_ACQ))); // R6

  AST_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (((modeQ == MODE_ACQ) || (modeQ == MODE_LOCK)) && !sts.candOk) |=> (modeQ == MODE_HOLD)); // R8

  AST_LOCK_NEEDS_PD: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_ACQ) && !pdLocked) |=> (modeQ != MODE_LOCK)); // R7

endmodule

// File: rtl/refsel_mode_ctrl.sv
module refsel_mode_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int PRIO_W   = 4,
  parameter int LOCK_W   = 8,
  localparam int IDX_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REFS-1:0]        refValid,
  input  logic [NUM_REFS*PRIO_W-1:0] refPrio,
  input  logic                       manualMode,
  input  logic [IDX_W-1:0]           manualIdx,
  input  logic                       revertEn,
  input  logic                       pdLocked,
  input  logic [LOCK_W-1:0]          lockDwell,
  output logic [IDX_W-1:0]           selIdx,
  output logic [1:0]                 mode,
  output logic                       switchStrobe,
  output logic                       bwLocked
);

  sel_ctl_t  ctl;
  sel_sts_t  sts;
  pll_mode_t modeQ;

  refsel_dp #(
    .NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W), .LOCK_W(LOCK_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refPrio(refPrio),
    .manualMode(manualMode), .manualIdx(manualIdx), .revertEn(revertEn),
    .lockDwell(lockDwell), .ctl(ctl), .sts(sts),
    .selIdx(selIdx), .switchStrobe(switchStrobe)
  );

  refsel_ctl ctl_i (
    .clk(clk), .rstN(rstN), .pdLocked(pdLocked), .sts(sts),
    .ctl(ctl), .mode(modeQ)
  );

  assign mode     = modeQ;
  assign bwLocked = (modeQ == MODE_LOCK); // R10

endmodule

// File: tb/refsel_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_mode_ctrl_tb_top;

  localparam int NR = 4;
  localparam int PW = 3;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NR-1:0] refValid = '0;
  logic [NR*PW-1:0] refPrio = '0;
  logic          manualMode = 1'b0;
  logic [1:0]    manualIdx = '0;
  logic          revertEn = 1'b1;
  logic          pdLocked = 1'b0;
  logic [LW-1:0] lockDwell = '0;
  logic [1:0]    selIdx;
  logic [1:0]    mode;
  logic          switchStrobe;
  logic          bwLocked;

  int    nVec = 0;
  int    nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  // behavioural model state
  int mMode = 0, mSel = 0, mCnt = 0;
  bit mSw = 0;

  always #2.5 clk = ~clk;

  refsel_mode_ctrl #(.NUM_REFS(NR), .PRIO_W(PW), .LOCK_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refPrio(refPrio),
    .manualMode(manualMode), .manualIdx(manualIdx), .revertEn(revertEn),
    .pdLocked(pdLocked), .lockDwell(lockDwell),
    .selIdx(selIdx), .mode(mode), .switchStrobe(switchStrobe), .bwLocked(bwLocked)
  );

  function automatic int prioOf(int i);
    return int'((refPrio >> (PW*i)) & 3'h7);
  endfunction

  always @(posedge clk) begin
    int  c, best, bp;
    bit  cOk, bOk, keep;
    if (!rstN) begin
      mMode = 0; mSel = 0; mCnt = 0; mSw = 0;
    end else begin
      bOk = 0; best = 0; bp = 99;
      for (int i = 0; i < NR; i++)
        if (refValid[i] && prioOf(i) < bp) begin bOk = 1; best = i; bp = prioOf(i); end
      keep = (mMode == 1) || (mMode == 2);
      if (manualMode) begin c = int'(manualIdx); cOk = refValid[manualIdx]; end   // R3
      else if (!revertEn && keep && refValid[mSel]) begin c = mSel; cOk = 1; end  // R5
      else begin c = best; cOk = bOk; end                                          // R2 R4
      mSw = 0;
      case (mMode)
        0: if (cOk) begin mSel = c; mCnt = 0; mMode = 1; end                       // R6
        1: begin
          if (!cOk) begin mMode = 3; mCnt = 0; end                                  // R8
          else if (c != mSel) begin mSel = c; mSw = 1; mCnt = 0; end                // R9
          else if (pdLocked) begin
            if (mCnt + 1 >= int'(lockDwell)) begin mMode = 2; mCnt = 0; end         // R7
            else mCnt++;
          end else mCnt = 0;
        end
        2: begin
          if (!cOk) begin mMode = 3; mCnt = 0; end
          else if (c != mSel) begin mSel = c; mSw = 1; mMode = 1; mCnt = 0; end     // R11
          else if (!pdLocked) begin mMode = 1; mCnt = 0; end
        end
        default: if (cOk) begin mSw = (c != mSel); mSel = c; mMode = 1; mCnt = 0; end
      endcase
    end
  end

  task automatic chk(string fld, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", curReq, fld, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("selIdx", int'(selIdx), mSel);
      chk("mode", int'(mode), mMode);
      chk("switchStrobe(R9)", int'(switchStrobe), int'(mSw));
      chk("bwLocked(R10)", int'(bwLocked), int'(mMode == 2));
    end
  endtask

  task automatic setPrio(int p0, int p1, int p2, int p3);
    refPrio = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endtask

  initial begin
    curReq = "R1";
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 mode after reset", int'(mode), 0);

    curReq = "R6";
    setPrio(3, 1, 1, 2);
    tick(2);
    refValid = 4'b1111;
    tick(1);
    curReq = "R2";                       // tie between 1 and 2 -> 1
    chk("R2 tie pick", int'(selIdx), 1);

    curReq = "R7";
    lockDwell = 4'd3; pdLocked = 1'b1;
    tick(2);
    pdLocked = 1'b0; tick(1);
    pdLocked = 1'b1; tick(2);
    chk("R7 not yet locked", int'(mode), 1);
    tick(1);
    chk("R7 locked", int'(mode), 2);
    curReq = "R10";
    tick(2);

    curReq = "R11";
    revertEn = 1'b1;
    refValid = 4'b1101;                  // selected 1 lost -> 2
    tick(1);
    chk("R11 back to acquiring", int'(mode), 1);
    tick(4);
    curReq = "R4";
    refValid = 4'b1111;                  // 1 returns and reclaims
    tick(1);
    chk("R4 revert", int'(selIdx), 1);
    tick(4);

    curReq = "R5";
    revertEn = 1'b0;
    refValid = 4'b1101; tick(2);
    refValid = 4'b1111; tick(3);
    chk("R5 kept", int'(selIdx), 2);
    pdLocked = 1'b0; tick(1);
    curReq = "R11";
    pdLocked = 1'b1; tick(4);

    curReq = "R8";
    refValid = 4'b0000; tick(2);
    chk("R8 holdover", int'(mode), 3);
    refValid = 4'b1000; tick(1);
    chk("R8 exit holdover", int'(mode), 1);

    curReq = "R3";
    manualMode = 1'b1; manualIdx = 2'd0;
    refValid = 4'b1001; tick(3);
    refValid = 4'b1000; tick(2);
    chk("R3 manual unqualified", int'(mode), 3);
    manualMode = 1'b0;

    curReq = "R7";
    lockDwell = 4'd0; refValid = 4'b0100; pdLocked = 1'b1;
    tick(3);
    chk("R7 zero dwell", int'(mode), 2);

    curReq = "R2";                       // all equal priorities
    setPrio(5, 5, 5, 5); revertEn = 1'b1; refValid = 4'b1110;
    tick(2);
    chk("R2 equal prio", int'(selIdx), 1);

    curReq = "R2 R4 R5 R8 R9";
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0) refValid = 4'($urandom);
      if ($urandom_range(0, 15) == 0) refPrio = 12'($urandom);
      if ($urandom_range(0, 15) == 0) revertEn = ~revertEn;
      if ($urandom_range(0, 31) == 0) manualMode = ~manualMode;
      if ($urandom_range(0, 7) == 0) manualIdx = 2'($urandom);
      if ($urandom_range(0, 15) == 0) lockDwell = 4'($urandom_range(0, 5));
      pdLocked = ($urandom_range(0, 5) != 0);
      tick(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog %s actual=running expected=finished", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule